// File: doc/BRIEF.md
# Triple-Copy Permutation State Store

This block holds a 256-entry, byte-wide permutation table of the kind used by a byte-oriented stream-cipher core. It keeps three identical copies of the table. Each copy has its own read port, so the i-indexed, j-indexed and t-indexed lookups of one cipher step can all be made in the same clock cycle without a true three-port RAM. The i and j copies supply the two operands of a swap. The t copy supplies the keystream byte.

A swap is one write cycle that carries two address/data pairs. Pair A stores the i-side value at the j address, and pair B stores the j-side value at the i address. Both pairs go to all three copies together, so the copies never drift apart. Reset loads every copy with the identity permutation. Reads are synchronous. Each read port registers its result, holds it while its strobe is low, and forwards data that is being written in the same cycle.

Top module: `sbox_triple_store`

## Requirements
- R1: While reset is released and no write has occurred, a read of address k on any of the three ports returns the value k (identity permutation).
- R2: A read strobe sampled high at a rising clock edge puts the addressed byte on that port's data output at that same edge, so the result is visible one cycle after the strobe is presented.
- R3: While a port's read strobe is low, that port's data output keeps its previous value.
- R4: The three read ports take independent addresses in the same cycle and each returns the content of its own address.
- R5: With the write enable high, the pair-A data is stored at the pair-A address and the pair-B data at the pair-B address, in all three copies, so any port reading those addresses later returns the written bytes.
- R6: When both write pairs target the same address, the pair-B data is the value that remains stored.
- R7: A read in the same cycle as a write to the address being read returns the newly written byte. Pair B takes priority over pair A when both match.
- R8: With the write enable low, the write addresses and data have no effect on the stored table.
- R9: While reset is asserted (active low), all three data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads identity into all copies |
| idx_rd_en | input | 1 | Read strobe for the i-side copy |
| idx_addr | input | ADDR_W | Read address for the i-side copy |
| idx_rdata | output | DATA_W | Registered read data from the i-side copy |
| jdx_rd_en | input | 1 | Read strobe for the j-side copy |
| jdx_addr | input | ADDR_W | Read address for the j-side copy |
| jdx_rdata | output | DATA_W | Registered read data from the j-side copy |
| tdx_rd_en | input | 1 | Read strobe for the keystream copy |
| tdx_addr | input | ADDR_W | Read address for the keystream copy |
| tdx_rdata | output | DATA_W | Registered read data from the keystream copy |
| wr_en | input | 1 | Swap write enable, applied to all copies |
| wr_a_addr | input | ADDR_W | Pair-A write address (j side) |
| wr_a_data | input | DATA_W | Pair-A write data (i-side value) |
| wr_b_addr | input | ADDR_W | Pair-B write address (i side) |
| wr_b_data | input | DATA_W | Pair-B write data (j-side value) |

## Verification
Every read result is due exactly one rising edge after its strobe is driven. A write becomes visible to a plain read from the next cycle on, and to a forwarded read in the same cycle. Each stimulus cycle, the driver computes the three expected port values from a reference table, marks each with the cycle in which it becomes due, and queues it. The monitor samples on the falling edge of that cycle and only pops the entries whose due stamp matches. A port whose strobe is low is queued with its previous expected value, which checks the hold behaviour in the same pass.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
   localparam int SBOX_COPIES = 3;

   typedef enum int {
      COPY_IDX = 0,
      COPY_JDX = 1,
      COPY_TDX = 2
   } sbox_copy_e;
endpackage

// File: rtl/sbox_bank.sv
module sbox_bank #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_a_addr,
   input  logic [DATA_W-1:0] wr_a_data,
   input  logic [ADDR_W-1:0] wr_b_addr,
   input  logic [DATA_W-1:0] wr_b_data,
   output logic [DATA_W-1:0] cell_q [DEPTH]
);

   initial begin
      assert (DATA_W >= ADDR_W) else $error("sbox_bank: DATA_W too narrow for identity fill");
      assert (ADDR_W >= 1) else $error("sbox_bank: ADDR_W must be positive");
   end

   // pair B is written last so it wins when both addresses coincide
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            cell_q[k] <= DATA_W'(k);
         end
      end else if (wr_en) begin
         cell_q[wr_a_addr] <= wr_a_data;
         cell_q[wr_b_addr] <= wr_b_data;
      end
   end

   AST_PAIR_A_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_a_addr != wr_b_addr) |=> cell_q[$past(wr_a_addr)] == $past(wr_a_data)); // R5

   AST_PAIR_B_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cell_q[$past(wr_b_addr)] == $past(wr_b_data)); // R6

endmodule

// File: rtl/sbox_rd_port.sv
module sbox_rd_port #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter bit RD_BYPASS = 1'b1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] cell_q [DEPTH],
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_a_addr,
   input  logic [DATA_W-1:0] wr_a_data,
   input  logic [ADDR_W-1:0] wr_b_addr,
   input  logic [DATA_W-1:0] wr_b_data,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] fetch;

   generate
      if (RD_BYPASS) begin : g_fwd
         always_comb begin
            if (wr_en && rd_addr == wr_b_addr) begin
               fetch = wr_b_data;
            end else if (wr_en && rd_addr == wr_a_addr) begin
               fetch = wr_a_data;
            end else begin
               fetch = cell_q[rd_addr];
            end
         end
      end else begin : g_plain
         always_comb fetch = cell_q[rd_addr];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= fetch;
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R3

endmodule

// File: rtl/sbox_triple_store.sv
module sbox_triple_store #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter bit RD_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_rd_en,
   input  logic [ADDR_W-1:0] idx_addr,
   output logic [DATA_W-1:0] idx_rdata,
   input  logic              jdx_rd_en,
   input  logic [ADDR_W-1:0] jdx_addr,
   output logic [DATA_W-1:0] jdx_rdata,
   input  logic              tdx_rd_en,
   input  logic [ADDR_W-1:0] tdx_addr,
   output logic [DATA_W-1:0] tdx_rdata,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_a_addr,
   input  logic [DATA_W-1:0] wr_a_data,
   input  logic [ADDR_W-1:0] wr_b_addr,
   input  logic [DATA_W-1:0] wr_b_data
);
   import sbox_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (SBOX_COPIES == 3) else $error("sbox_triple_store: three copies expected");
   end

   logic              rd_en_v [SBOX_COPIES];
   logic [ADDR_W-1:0] rd_addr_v [SBOX_COPIES];
   logic [DATA_W-1:0] rd_q_v [SBOX_COPIES];

   always_comb begin
      rd_en_v[COPY_IDX]   = idx_rd_en;
      rd_addr_v[COPY_IDX] = idx_addr;
      rd_en_v[COPY_JDX]   = jdx_rd_en;
      rd_addr_v[COPY_JDX] = jdx_addr;
      rd_en_v[COPY_TDX]   = tdx_rd_en;
      rd_addr_v[COPY_TDX] = tdx_addr;
   end

   assign idx_rdata = rd_q_v[COPY_IDX];
   assign jdx_rdata = rd_q_v[COPY_JDX];
   assign tdx_rdata = rd_q_v[COPY_TDX];

   generate
      for (genvar b = 0; b < SBOX_COPIES; b++) begin : g_copy
         logic [DATA_W-1:0] cells [DEPTH];

         sbox_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_a_addr (wr_a_addr),
            .wr_a_data (wr_a_data),
            .wr_b_addr (wr_b_addr),
            .wr_b_data (wr_b_data),
            .cell_q    (cells)
         );

         sbox_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_BYPASS(RD_BYPASS)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_en     (rd_en_v[b]),
            .rd_addr   (rd_addr_v[b]),
            .cell_q    (cells),
            .wr_en     (wr_en),
            .wr_a_addr (wr_a_addr),
            .wr_a_data (wr_a_data),
            .wr_b_addr (wr_b_addr),
            .wr_b_data (wr_b_data),
            .rdata     (rd_q_v[b])
         );
      end
   endgenerate

   AST_COPIES_AGREE_IJ: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_rd_en && jdx_rd_en && idx_addr == jdx_addr) |=> idx_rdata == jdx_rdata); // R5

   AST_COPIES_AGREE_JT: assert property (@(posedge clk) disable iff (!rst_n)
      (jdx_rd_en && tdx_rd_en && jdx_addr == tdx_addr) |=> jdx_rdata == tdx_rdata); // R5

   AST_FRESH_READ_T: assert property (@(posedge clk) disable iff (!rst_n)
      (RD_BYPASS && wr_en && tdx_rd_en && tdx_addr == wr_b_addr) |=> tdx_rdata == $past(wr_b_data)); // R7

endmodule

// File: tb/tb_sbox_triple_store.sv
module tb_sbox_triple_store;

   localparam int DW = 8;
   localparam int AW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en [3];
   logic [AW-1:0] rd_addr [3];
   logic [DW-1:0] q [3];
   logic          wr_en = 1'b0;
   logic [AW-1:0] wa = '0, wb = '0;
   logic [DW-1:0] da = '0, dbv = '0;

   always #5 clk = ~clk;

   sbox_triple_store #(.DATA_W(DW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .idx_rd_en(rd_en[0]), .idx_addr(rd_addr[0]), .idx_rdata(q[0]),
      .jdx_rd_en(rd_en[1]), .jdx_addr(rd_addr[1]), .jdx_rdata(q[1]),
      .tdx_rd_en(rd_en[2]), .tdx_addr(rd_addr[2]), .tdx_rdata(q[2]),
      .wr_en(wr_en), .wr_a_addr(wa), .wr_a_data(da), .wr_b_addr(wb), .wr_b_data(dbv)
   );

   typedef struct {
      int            due;
      int            port;
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   item_t         sb_q[$];
   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] last_exp [3];
   int            cyc = 0;
   int            checks = 0;
   int            fails = 0;
   bit            done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare every item whose due cycle has arrived
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (q[it.port] !== it.exp) begin
            fails++;
            $display("FAIL %s port %0d cycle %0d: got %0h expected %0h", it.tag, it.port, cyc, q[it.port], it.exp);
         end
      end
   end

   task automatic direct_check(input int port, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (q[port] !== exp) begin
         fails++;
         $display("FAIL %s port %0d: got %0h expected %0h", tag, port, q[port], exp);
      end
   endtask

   // driver: one cycle of stimulus, called just after a falling edge
   task automatic drive(input bit we, input logic [AW-1:0] a_ad, input logic [DW-1:0] a_d,
                        input logic [AW-1:0] b_ad, input logic [DW-1:0] b_d,
                        input bit [2:0] en, input logic [AW-1:0] r0, input logic [AW-1:0] r1,
                        input logic [AW-1:0] r2, input string tag);
      logic [AW-1:0] ra [3];
      ra[0] = r0; ra[1] = r1; ra[2] = r2;
      wr_en = we; wa = a_ad; da = a_d; wb = b_ad; dbv = b_d;
      for (int p = 0; p < 3; p++) begin
         item_t it;
         rd_en[p] = en[p];
         rd_addr[p] = ra[p];
         it.due = cyc + 1;
         it.port = p;
         it.tag = tag;
         if (!en[p]) begin
            it.exp = last_exp[p];
            it.tag = "R3";
         end else if (we && ra[p] == b_ad) begin
            it.exp = b_d;
            it.tag = "R7";
         end else if (we && ra[p] == a_ad) begin
            it.exp = a_d;
            it.tag = "R7";
         end else begin
            it.exp = model[ra[p]];
         end
         last_exp[p] = it.exp;
         sb_q.push_back(it);
      end
      if (we) begin
         model[a_ad] = a_d;
         model[b_ad] = b_d;
      end
      @(negedge clk);
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
   end

   initial begin
      for (int p = 0; p < 3; p++) begin
         rd_en[p] = 1'b0;
         rd_addr[p] = '0;
         last_exp[p] = '0;
      end
      for (int k = 0; k < DEPTH; k++) model[k] = DW'(k);
      repeat (3) @(negedge clk);
      for (int p = 0; p < 3; p++) direct_check(p, '0, "R9");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 identity on all ports, R4 independent addresses, R2 one-cycle latency
      for (int k = 0; k < DEPTH; k++) begin
         drive(1'b0, '0, '0, '0, '0, 3'b111, AW'(k), AW'(k + 85), AW'(255 - k), "R1");
      end
      drive(1'b0, '0, '0, '0, '0, 3'b111, 8'd3, 8'd200, 8'd77, "R4");
      drive(1'b0, '0, '0, '0, '0, 3'b100, '0, '0, 8'd12, "R2");

      // R5 swap stored in all copies
      drive(1'b1, 8'd10, 8'd33, 8'd40, 8'd99, 3'b000, '0, '0, '0, "R5");
      drive(1'b0, '0, '0, '0, '0, 3'b111, 8'd10, 8'd10, 8'd10, "R5");
      drive(1'b0, '0, '0, '0, '0, 3'b111, 8'd40, 8'd40, 8'd40, "R5");

      // R8 disabled write leaves table untouched
      drive(1'b0, 8'd50, 8'hEE, 8'd51, 8'hDD, 3'b000, '0, '0, '0, "R8");
      drive(1'b0, '0, '0, '0, '0, 3'b111, 8'd50, 8'd51, 8'd50, "R8");

      // R6 coincident addresses: pair B stays
      drive(1'b1, 8'd60, 8'h11, 8'd60, 8'h22, 3'b000, '0, '0, '0, "R6");
      drive(1'b0, '0, '0, '0, '0, 3'b111, 8'd60, 8'd60, 8'd60, "R6");

      // R7 same-cycle forwarding, pair A hit, pair B hit, both hit
      drive(1'b1, 8'd70, 8'hA5, 8'd71, 8'h5A, 3'b111, 8'd70, 8'd71, 8'd72, "R7");
      drive(1'b1, 8'd80, 8'h01, 8'd80, 8'h02, 3'b111, 8'd80, 8'd80, 8'd80, "R7");
      drive(1'b0, '0, '0, '0, '0, 3'b111, 8'd70, 8'd71, 8'd80, "R5");

      // R3 hold while strobe low, with writes going on
      drive(1'b1, 8'd90, 8'h77, 8'd91, 8'h66, 3'b010, 8'd90, 8'd91, 8'd90, "R3");
      drive(1'b0, '0, '0, '0, '0, 3'b000, 8'd5, 8'd6, 8'd7, "R3");

      // mixed swap traffic against the reference table
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] x, y;
         x = AW'($urandom_range(0, DEPTH - 1));
         y = AW'($urandom_range(0, DEPTH - 1));
         drive(1'($urandom_range(0, 1)), x, model[y], y, model[x], 3'($urandom_range(0, 7)),
               AW'($urandom_range(0, DEPTH - 1)), y, AW'($urandom_range(0, DEPTH - 1)), "R5");
      end
      drive(1'b0, '0, '0, '0, '0, 3'b000, '0, '0, '0, "R3");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule